// File: doc/BRIEF.md
# Paged NIC Register Front End

This block is the host-facing register decoder of a ring-buffer network controller. The host reaches it through a 32-byte I/O window. The upper two offset bits pick one of three regions: the register file, the data port, or a reset trap. Inside the register file, a 4-bit offset and a 2-bit page number taken from the command byte select a register. Reads and writes use separate lookup maps, so the same offset can reach different storage depending on direction.

The block holds the register bytes and the command byte. It turns command writes into a run/stop state, a reset status flag, a one-cycle transmit request and a one-cycle remote-DMA start. Data-port accesses are passed on as one-cycle strobes to the DMA engine. A 16-bit access to the register file is carried out as two byte accesses on consecutive cycles. Read data is registered. A read that decodes to nothing leaves the returned byte unchanged.

Top module: `nic_regfront`

## Requirements
- R1: Offset bits 4:3 choose the region. Values 00 and 01 reach the register file. Value 10 gives a one-cycle `data_req` in the cycle after the access, with `data_wr` and `data_wide` copied from the access. Value 11 gives a one-cycle `dev_reset` in the cycle after the access, on a read or a write.
- R2: Hard reset and a device reset both leave the device in the same state. The command byte reads 0x21 while `tx_busy` is low. The data configuration register (page 2 read, offset 14) reads 0x04. The interrupt mask (offset 15) and transmit configuration (offset 13) read 0. The page is 0. `dma_addr` and `dma_cnt` are 0. The reset flag is set: page 0 offset 7 reads 0x80. `nic_en` is low. A device reset leaves every other register unchanged.
- R3: Offset 0 is the command byte on every page, for reads and writes. Bits 7:6 of the written command select the page. Read data appears on `acc_rdata` in the cycle after the access.
- R4: On page 0, writes to offsets 1–6 and 8–15 store bytes, and offset 7 is the interrupt status. On page 0, reads see offset 3, offset 8 and offset 9. Offsets 8 and 9 return the low and high bytes of `dma_addr`. The page-0 bytes at offsets 1, 2, 4 and 12–15 read back on page 2 at the same offsets. `dma_addr` is {offset 9, offset 8} and `dma_cnt` is {offset 11, offset 10}. Page 1 offsets 1–15 are readable and writable.
- R5: A write to page 2 or page 3 at any offset other than 0 is discarded. A read that decodes to no register leaves `acc_rdata` unchanged. This covers all of page 3 except offset 0, and the unlisted offsets of pages 0 and 2.
- R6: Bit 2 of the command byte is never stored. On a read it shows the `tx_busy` input.
- R7: A command write with bit 2 set gives a one-cycle `tx_req` if the device is running once that same write's stop/start bits have been applied. In that cycle `tx_addr` is the page-0 offset-4 byte shifted left by 8 and truncated to 14 bits, and `tx_len` is {offset 6, offset 5}.
- R8: A command write with bit 0 (stop) set clears `nic_en` and sets the reset flag. If the device was running, bit 1 of the stored command is forced to 1. A write with bit 1 (start) and without bit 0 sets `nic_en` and clears the reset flag.
- R9: The command field in bits 5:3 starts remote DMA. Value 001 gives a one-cycle `dma_start` with `dma_dir`=0 (read). Value 010 gives `dma_start` with `dma_dir`=1 (write). Values 000, 011 and 1xx give no pulse.
- R10: A 16-bit register access takes two cycles. The low byte goes to the given offset. The high byte goes to (offset+1) mod 16 and is decoded with the page as it stands after the low byte. A 16-bit read returns the high byte in `acc_rdata[15:8]`. An 8-bit read updates only `acc_rdata[7:0]`.
- R11: Writing page 0 offset 7 with bit 7 set clears the reset flag. Bit 7 clear leaves the flag unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| acc_valid | input | 1 | Host access presented this cycle |
| acc_write | input | 1 | 1 = write, 0 = read |
| acc_wide | input | 1 | 1 = 16-bit access |
| acc_off | input | 5 | Offset within the I/O window |
| acc_wdata | input | 16 | Write data |
| acc_rdata | output | 16 | Registered read data |
| tx_busy | input | 1 | Transmission in progress |
| nic_en | output | 1 | Device running |
| rst_flag | output | 1 | Reset status flag |
| tx_req | output | 1 | Transmit request pulse |
| tx_addr | output | 14 | Transmit start address |
| tx_len | output | 16 | Transmit length |
| dma_start | output | 1 | Remote-DMA start pulse |
| dma_dir | output | 1 | Remote-DMA direction, 1 = write |
| dma_addr | output | 16 | Remote-DMA start address |
| dma_cnt | output | 16 | Remote-DMA byte count |
| data_req | output | 1 | Data-port access pulse |
| data_wr | output | 1 | Data-port access was a write |
| data_wide | output | 1 | Data-port access was 16-bit |
| dev_reset | output | 1 | Device reset pulse |

## Verification
One command byte can carry stop, start, a transmit request and a DMA code together, so these functions meet in a single cycle. The bench writes stop+start+transmit to a running device and expects no transmit request, a stopped device and the start bit forced on. It then writes start+transmit to a stopped device and expects the request to fire, because the run state is taken after the same write's start bit is applied. A 16-bit write whose low byte changes the page shows the page switch and the high-byte store landing in consecutive cycles. The bench judges this by reading the stored byte back on the new page.

// File: rtl/nic_regfront_pkg.sv
package nic_regfront_pkg;
  localparam int DW    = 8;
  localparam int RAW   = 4;
  localparam int NREG  = 1 << RAW;
  localparam int OFFW  = RAW + 1;

  typedef logic [DW-1:0]  byte_t;
  typedef logic [RAW-1:0] roff_t;

  typedef enum logic [2:0] {SEL_NONE, SEL_CR, SEL_B0, SEL_B1, SEL_ISR} sel_e;

  localparam roff_t OFF_CMD  = 4'd0;
  localparam roff_t OFF_STAT = 4'd7;
  localparam roff_t OFF_TXPG = 4'd4;
  localparam roff_t OFF_TXL0 = 4'd5;
  localparam roff_t OFF_TXL1 = 4'd6;
  localparam roff_t OFF_DA0  = 4'd8;
  localparam roff_t OFF_DA1  = 4'd9;
  localparam roff_t OFF_DC0  = 4'd10;
  localparam roff_t OFF_DC1  = 4'd11;
  localparam roff_t OFF_TCFG = 4'd13;
  localparam roff_t OFF_DCFG = 4'd14;
  localparam roff_t OFF_MASK = 4'd15;

  // read map: page + offset -> storage source
  function automatic sel_e rd_map(input logic [1:0] pg, input roff_t off);
    sel_e s;
    s = SEL_NONE;
    if (off == OFF_CMD) s = SEL_CR;
    else begin
      case (pg)
        2'd0: begin
          if (off == OFF_STAT) s = SEL_ISR;
          else if (off == 4'd3 || off == OFF_DA0 || off == OFF_DA1) s = SEL_B0;
        end
        2'd1: s = SEL_B1;
        2'd2: if (off == 4'd1 || off == 4'd2 || off == OFF_TXPG || off >= 4'd12) s = SEL_B0;
        default: s = SEL_NONE;
      endcase
    end
    return s;
  endfunction

  // write map: page + offset -> storage target
  function automatic sel_e wr_map(input logic [1:0] pg, input roff_t off);
    sel_e s;
    s = SEL_NONE;
    if (off == OFF_CMD) s = SEL_CR;
    else begin
      case (pg)
        2'd0: s = (off == OFF_STAT) ? SEL_ISR : SEL_B0;
        2'd1: s = SEL_B1;
        default: s = SEL_NONE;
      endcase
    end
    return s;
  endfunction
endpackage

// File: rtl/nic_cmd_ctl.sv
module nic_cmd_ctl
  import nic_regfront_pkg::*;
#(
  parameter byte_t CR_INIT = 8'h21
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       soft_rst,
  input  logic       cr_we,
  input  logic       isr_we,
  input  byte_t      wdata,
  input  logic       tx_busy,
  output logic [1:0] page,
  output byte_t      cr_rdata,
  output logic       nic_en,
  output logic       rst_flag,
  output logic       tx_req,
  output logic       dma_start,
  output logic       dma_dir
);
  byte_t cr_q, cr_d;
  logic  en_q, en_d, fl_q, fl_d, tx_d, ds_d, dir_d;

  always_comb begin
    cr_d  = cr_q;
    en_d  = en_q;
    fl_d  = fl_q;
    tx_d  = 1'b0;
    ds_d  = 1'b0;
    dir_d = dma_dir;
    if (soft_rst) begin
      cr_d = CR_INIT;
      en_d = 1'b0;
      fl_d = 1'b1;
    end else if (cr_we) begin
      cr_d = wdata & ~byte_t'(8'h04);
      if (wdata[0]) begin
        if (en_q) begin
          cr_d[1] = 1'b1;
          en_d    = 1'b0;
        end
        fl_d = 1'b1;
      end else if (wdata[1]) begin
        en_d = 1'b1;
        fl_d = 1'b0;
      end
      case (wdata[5:3])
        3'b001: begin ds_d = 1'b1; dir_d = 1'b0; end
        3'b010: begin ds_d = 1'b1; dir_d = 1'b1; end
        default: ;
      endcase
      tx_d = wdata[2] & en_d;
    end else if (isr_we && wdata[7]) begin
      fl_d = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cr_q      <= CR_INIT;
      en_q      <= 1'b0;
      fl_q      <= 1'b1;
      tx_req    <= 1'b0;
      dma_start <= 1'b0;
      dma_dir   <= 1'b0;
    end else begin
      cr_q      <= cr_d;
      en_q      <= en_d;
      fl_q      <= fl_d;
      tx_req    <= tx_d;
      dma_start <= ds_d;
      dma_dir   <= dir_d;
    end
  end

  assign page     = cr_q[7:6];
  assign cr_rdata = cr_q | {5'b0, tx_busy, 2'b0};
  assign nic_en   = en_q;
  assign rst_flag = fl_q;
endmodule

// File: rtl/nic_reg_bank.sv
module nic_reg_bank
  import nic_regfront_pkg::*;
#(
  parameter byte_t DCR_INIT = 8'h04
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  soft_rst,
  input  logic                  we0,
  input  logic                  we1,
  input  roff_t                 waddr,
  input  byte_t                 wdata,
  output logic [NREG-1:0][DW-1:0] bank0,
  output logic [NREG-1:0][DW-1:0] bank1
);
  logic [NREG-1:0][DW-1:0] b0_d, b1_d;

  always_comb begin
    b0_d = bank0;
    b1_d = bank1;
    if (soft_rst) begin
      b0_d[OFF_DA0]  = '0;
      b0_d[OFF_DA1]  = '0;
      b0_d[OFF_DC0]  = '0;
      b0_d[OFF_DC1]  = '0;
      b0_d[OFF_TCFG] = '0;
      b0_d[OFF_DCFG] = DCR_INIT;
      b0_d[OFF_MASK] = '0;
    end else begin
      if (we0) b0_d[waddr] = wdata;
      if (we1) b1_d[waddr] = wdata;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < NREG; i++) begin
        bank0[i] <= (i == int'(OFF_DCFG)) ? DCR_INIT : '0;
        bank1[i] <= '0;
      end
    end else begin
      bank0 <= b0_d;
      bank1 <= b1_d;
    end
  end
endmodule

// File: rtl/nic_regfront.sv
module nic_regfront
  import nic_regfront_pkg::*;
#(
  parameter byte_t CR_INIT   = 8'h21,
  parameter byte_t DCR_INIT  = 8'h04,
  parameter int    TX_ADDR_W = 14
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 acc_valid,
  input  logic                 acc_write,
  input  logic                 acc_wide,
  input  logic [OFFW-1:0]      acc_off,
  input  logic [2*DW-1:0]      acc_wdata,
  output logic [2*DW-1:0]      acc_rdata,
  input  logic                 tx_busy,
  output logic                 nic_en,
  output logic                 rst_flag,
  output logic                 tx_req,
  output logic [TX_ADDR_W-1:0] tx_addr,
  output logic [2*DW-1:0]      tx_len,
  output logic                 dma_start,
  output logic                 dma_dir,
  output logic [2*DW-1:0]      dma_addr,
  output logic [2*DW-1:0]      dma_cnt,
  output logic                 data_req,
  output logic                 data_wr,
  output logic                 data_wide,
  output logic                 dev_reset
);
  logic       pend_q, pend_d, pwr_q, pwr_d;
  roff_t      poff_q, poff_d;
  byte_t      pdat_q, pdat_d;
  logic [1:0] region, page;
  logic       take, hit_reg, hit_dat, hit_rst;
  logic       cyc_valid, cyc_write, cyc_hi;
  roff_t      cyc_off;
  byte_t      cyc_data, cr_rdata, rbyte, rlo_q, rlo_d, rhi_q, rhi_d;
  logic       rbyte_ok;
  sel_e       rsel, wsel;
  logic       dreq_d, dwr_d, dwide_d, drst_d;
  logic [NREG-1:0][DW-1:0] bank0, bank1;

  assign region  = acc_off[OFFW-1:OFFW-2];
  assign take    = acc_valid & ~pend_q;
  assign hit_reg = take & ~region[1];
  assign hit_dat = take & (region == 2'b10);
  assign hit_rst = take & (region == 2'b11);

  // byte-access bus: pending high byte has priority over a new access
  always_comb begin
    if (pend_q) begin
      cyc_valid = 1'b1;
      cyc_write = pwr_q;
      cyc_off   = poff_q;
      cyc_data  = pdat_q;
      cyc_hi    = 1'b1;
    end else begin
      cyc_valid = hit_reg;
      cyc_write = acc_write;
      cyc_off   = acc_off[RAW-1:0];
      cyc_data  = acc_wdata[DW-1:0];
      cyc_hi    = 1'b0;
    end
  end

  assign rsel = rd_map(page, cyc_off);
  assign wsel = wr_map(page, cyc_off);

  always_comb begin
    rbyte_ok = 1'b1;
    case (rsel)
      SEL_CR:  rbyte = cr_rdata;
      SEL_B0:  rbyte = bank0[cyc_off];
      SEL_B1:  rbyte = bank1[cyc_off];
      SEL_ISR: rbyte = {rst_flag, 7'b0};
      default: begin rbyte = '0; rbyte_ok = 1'b0; end
    endcase
  end

  always_comb begin
    pend_d  = hit_reg & acc_wide;
    poff_d  = acc_off[RAW-1:0] + roff_t'(1);
    pdat_d  = acc_wdata[2*DW-1:DW];
    pwr_d   = acc_write;
    rlo_d   = rlo_q;
    rhi_d   = rhi_q;
    if (cyc_valid && !cyc_write && rbyte_ok) begin
      if (cyc_hi) rhi_d = rbyte;
      else        rlo_d = rbyte;
    end
    dreq_d  = hit_dat;
    dwr_d   = hit_dat & acc_write;
    dwide_d = hit_dat & acc_wide;
    drst_d  = hit_rst;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_q    <= 1'b0;
      poff_q    <= '0;
      pdat_q    <= '0;
      pwr_q     <= 1'b0;
      rlo_q     <= '0;
      rhi_q     <= '0;
      data_req  <= 1'b0;
      data_wr   <= 1'b0;
      data_wide <= 1'b0;
      dev_reset <= 1'b0;
    end else begin
      pend_q    <= pend_d;
      poff_q    <= poff_d;
      pdat_q    <= pdat_d;
      pwr_q     <= pwr_d;
      rlo_q     <= rlo_d;
      rhi_q     <= rhi_d;
      data_req  <= dreq_d;
      data_wr   <= dwr_d;
      data_wide <= dwide_d;
      dev_reset <= drst_d;
    end
  end

  nic_cmd_ctl #(.CR_INIT(CR_INIT)) u_cmd (
    .clk      (clk),
    .rst_n    (rst_n),
    .soft_rst (hit_rst),
    .cr_we    (cyc_valid & cyc_write & (wsel == SEL_CR)),
    .isr_we   (cyc_valid & cyc_write & (wsel == SEL_ISR)),
    .wdata    (cyc_data),
    .tx_busy  (tx_busy),
    .page     (page),
    .cr_rdata (cr_rdata),
    .nic_en   (nic_en),
    .rst_flag (rst_flag),
    .tx_req   (tx_req),
    .dma_start(dma_start),
    .dma_dir  (dma_dir)
  );

  nic_reg_bank #(.DCR_INIT(DCR_INIT)) u_bank (
    .clk     (clk),
    .rst_n   (rst_n),
    .soft_rst(hit_rst),
    .we0     (cyc_valid & cyc_write & (wsel == SEL_B0)),
    .we1     (cyc_valid & cyc_write & (wsel == SEL_B1)),
    .waddr   (cyc_off),
    .wdata   (cyc_data),
    .bank0   (bank0),
    .bank1   (bank1)
  );

  assign acc_rdata = {rhi_q, rlo_q};
  assign tx_addr   = TX_ADDR_W'({bank0[OFF_TXPG], 8'h00});
  assign tx_len    = {bank0[OFF_TXL1], bank0[OFF_TXL0]};
  assign dma_addr  = {bank0[OFF_DA1], bank0[OFF_DA0]};
  assign dma_cnt   = {bank0[OFF_DC1], bank0[OFF_DC0]};
endmodule

// File: rtl/nic_regfront_chk.sv
module nic_regfront_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        acc_valid,
  input logic [4:0]  acc_off,
  input logic        pend_q,
  input logic [1:0]  page,
  input logic        dev_reset,
  input logic        data_req,
  input logic        tx_req,
  input logic        nic_en,
  input logic        rst_flag,
  input logic [15:0] dma_addr,
  input logic [15:0] dma_cnt
);
  // R1
  reset_region_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_valid && !pend_q && acc_off[4:3] == 2'b11) |=> dev_reset);

  // R1
  data_region_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_valid && !pend_q && acc_off[4:3] == 2'b10) |=> (data_req && !dev_reset));

  // R2
  soft_reset_state_chk: assert property (@(posedge clk) disable iff (!rst_n)
    dev_reset |-> (page == 2'd0 && rst_flag && !nic_en && dma_addr == 16'h0 && dma_cnt == 16'h0));

  // R7
  tx_needs_run_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tx_req |-> nic_en);

  // R8
  stop_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_flag) |-> !nic_en);

  // R10
  wide_two_cycle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pend_q |=> !pend_q);
endmodule

bind nic_regfront nic_regfront_chk u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .acc_valid(acc_valid),
  .acc_off  (acc_off),
  .pend_q   (pend_q),
  .page     (page),
  .dev_reset(dev_reset),
  .data_req (data_req),
  .tx_req   (tx_req),
  .nic_en   (nic_en),
  .rst_flag (rst_flag),
  .dma_addr (dma_addr),
  .dma_cnt  (dma_cnt)
);

// File: tb/nic_regfront_test.sv
module nic_regfront_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        acc_valid = 1'b0, acc_write = 1'b0, acc_wide = 1'b0;
  logic [4:0]  acc_off = '0;
  logic [15:0] acc_wdata = '0;
  logic [15:0] acc_rdata;
  logic        tx_busy = 1'b0;
  logic        nic_en, rst_flag, tx_req, dma_start, dma_dir;
  logic [13:0] tx_addr;
  logic [15:0] tx_len, dma_addr, dma_cnt;
  logic        data_req, data_wr, data_wide, dev_reset;

  int n_chk = 0, n_bad = 0;
  logic [7:0] m0 [16];
  logic [7:0] m1 [16];
  logic       mflag;

  always #4 clk = ~clk;

  nic_regfront uut (
    .clk(clk), .rst_n(rst_n), .acc_valid(acc_valid), .acc_write(acc_write),
    .acc_wide(acc_wide), .acc_off(acc_off), .acc_wdata(acc_wdata), .acc_rdata(acc_rdata),
    .tx_busy(tx_busy), .nic_en(nic_en), .rst_flag(rst_flag), .tx_req(tx_req),
    .tx_addr(tx_addr), .tx_len(tx_len), .dma_start(dma_start), .dma_dir(dma_dir),
    .dma_addr(dma_addr), .dma_cnt(dma_cnt), .data_req(data_req), .data_wr(data_wr),
    .data_wide(data_wide), .dev_reset(dev_reset)
  );

  task automatic chk(input string r, input logic [15:0] act, input logic [15:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", r, act, exp);
    end
  endtask

  task automatic access(input logic wr, input logic wide, input logic [4:0] off, input logic [15:0] d);
    @(negedge clk);
    acc_valid = 1'b1; acc_write = wr; acc_wide = wide; acc_off = off; acc_wdata = d;
    @(negedge clk);
    acc_valid = 1'b0;
    if (wide && !off[4]) @(negedge clk);
  endtask

  task automatic bwr(input logic [4:0] off, input logic [7:0] d);
    access(1'b1, 1'b0, off, {8'h00, d});
  endtask

  task automatic brd(input logic [4:0] off);
    access(1'b0, 1'b0, off, 16'h0);
  endtask

  task automatic setpage(input int p);
    bwr(5'd0, {p[1:0], 6'h20});
  endtask

  // expected byte for a read; -1 means no register (stale)
  function automatic int model_rd(input int p, input int off);
    if (p == 0) begin
      if (off == 7) return {mflag, 7'b0};
      if (off == 3 || off == 8 || off == 9) return int'(m0[off]);
      return -1;
    end
    if (p == 1) return int'(m1[off]);
    if (p == 2 && (off == 1 || off == 2 || off == 4 || off >= 12)) return int'(m0[off]);
    return -1;
  endfunction

  task automatic model_wr(input int p, input int off, input logic [7:0] d);
    if (p == 0) begin
      if (off == 7) begin if (d[7]) mflag = 1'b0; end
      else m0[off] = d;
    end else if (p == 1) m1[off] = d;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog actual=running expected=done");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    logic [15:0] prev;
    for (int i = 0; i < 16; i++) begin m0[i] = 8'h00; m1[i] = 8'h00; end
    m0[14] = 8'h04;
    mflag = 1'b1;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R2 hard reset state
    chk("R2 en", {15'b0, nic_en}, 16'h0);
    chk("R2 dma_addr", dma_addr, 16'h0);
    chk("R2 dma_cnt", dma_cnt, 16'h0);
    brd(5'd0);  chk("R2 cmd", acc_rdata, 16'h0021);
    brd(5'd7);  chk("R2 isr", acc_rdata, 16'h0080);
    setpage(2);
    brd(5'd14); chk("R2 dcfg", acc_rdata, 16'h0004);
    brd(5'd13); chk("R2 tcfg", acc_rdata, 16'h0000);
    brd(5'd15); chk("R2 mask", acc_rdata, 16'h0000);

    // R4 R5 R11 write sweep over all pages/offsets
    for (int p = 0; p < 4; p++) begin
      setpage(p);
      for (int off = 1; off < 16; off++) begin
        logic [7:0] v;
        v = 8'((p * 37 + off * 11) ^ 8'h5A);
        bwr(5'(off), v);
        model_wr(p, off, v);
      end
    end
    // R3 R4 R5 readback sweep
    for (int p = 0; p < 4; p++) begin
      setpage(p);
      brd(5'd0);
      chk("R3 cmd page", acc_rdata & 16'h00FF, {8'h00, p[1:0], 6'h20});
      for (int off = 1; off < 16; off++) begin
        int e;
        prev = acc_rdata;
        brd(5'(off));
        e = model_rd(p, off);
        if (e < 0) chk("R5 stale read", acc_rdata, prev);
        else       chk("R4 map read", acc_rdata & 16'h00FF, 16'(e));
      end
    end
    chk("R4 dma_addr", dma_addr, {m0[9], m0[8]});
    chk("R4 dma_cnt", dma_cnt, {m0[11], m0[10]});

    // R1 R2 device reset by write and by read
    bwr(5'h18, 8'h00);
    chk("R1 reset pulse w", {14'b0, dev_reset, data_req}, 16'h0002);
    m0[8] = 0; m0[9] = 0; m0[10] = 0; m0[11] = 0; m0[13] = 0; m0[14] = 8'h04; m0[15] = 0;
    mflag = 1'b1;
    brd(5'd0);  chk("R2 cmd after dev reset", acc_rdata & 16'h00FF, 16'h0021);
    brd(5'd7);  chk("R2 isr after dev reset", acc_rdata & 16'h00FF, 16'h0080);
    chk("R2 dma after dev reset", dma_addr | dma_cnt, 16'h0);
    access(1'b0, 1'b0, 5'h1C, 16'h0);
    chk("R1 reset pulse r", {15'b0, dev_reset}, 16'h0001);
    setpage(2);
    brd(5'd14); chk("R2 dcfg after dev reset", acc_rdata & 16'h00FF, 16'h0004);
    brd(5'd1);  chk("R2 kept reg", acc_rdata & 16'h00FF, {8'h00, m0[1]});
    setpage(0);

    // R1 data port
    bwr(5'h10, 8'h33);
    chk("R1 data wr", {13'b0, data_req, data_wr, data_wide}, 16'h0006);
    access(1'b0, 1'b1, 5'h15, 16'h0);
    chk("R1 data rd wide", {13'b0, data_req, data_wr, data_wide}, 16'h0005);
    @(negedge clk);
    chk("R1 data pulse end", {15'b0, data_req}, 16'h0);

    // R8 start
    bwr(5'd0, 8'h22);
    chk("R8 start en", {15'b0, nic_en}, 16'h0001);
    brd(5'd7); chk("R8 start clears flag", acc_rdata & 16'h00FF, 16'h0000);

    // R7 transmit request
    bwr(5'd4, 8'hC6); bwr(5'd5, 8'h3C); bwr(5'd6, 8'h05);
    bwr(5'd0, 8'h26);
    chk("R7 tx_req", {15'b0, tx_req}, 16'h0001);
    chk("R7 tx_addr", {2'b0, tx_addr}, 16'h0600);
    chk("R7 tx_len", tx_len, 16'h053C);
    @(negedge clk);
    chk("R7 tx pulse end", {15'b0, tx_req}, 16'h0);

    // R6 transmit bit reads busy
    tx_busy = 1'b1;
    brd(5'd0); chk("R6 busy read", acc_rdata & 16'h00FF, 16'h0026);
    tx_busy = 1'b0;
    brd(5'd0); chk("R6 idle read", acc_rdata & 16'h00FF, 16'h0022);

    // R8 R7 stop+start+tx together while running
    bwr(5'd0, 8'h27);
    chk("R7 no tx on stop", {15'b0, tx_req}, 16'h0);
    chk("R8 stop disables", {15'b0, nic_en}, 16'h0);
    brd(5'd0); chk("R8 start forced", acc_rdata & 16'h00FF, 16'h0023);
    brd(5'd7); chk("R8 stop sets flag", acc_rdata & 16'h00FF, 16'h0080);
    bwr(5'd0, 8'h25);
    chk("R7 no tx stopped", {15'b0, tx_req}, 16'h0);
    brd(5'd0); chk("R8 stop when idle", acc_rdata & 16'h00FF, 16'h0021);
    bwr(5'd0, 8'h06);
    chk("R7 start+tx fires", {14'b0, tx_req, nic_en}, 16'h0003);
    chk("R9 field 000", {15'b0, dma_start}, 16'h0);

    // R9 remote DMA commands
    bwr(5'd0, 8'h0A); chk("R9 dma read", {14'b0, dma_start, dma_dir}, 16'h0002);
    bwr(5'd0, 8'h12); chk("R9 dma write", {14'b0, dma_start, dma_dir}, 16'h0003);
    bwr(5'd0, 8'h1A); chk("R9 send none", {15'b0, dma_start}, 16'h0);
    bwr(5'd0, 8'h2A); chk("R9 abort none", {15'b0, dma_start}, 16'h0);

    // R11 status flag clear
    bwr(5'd0, 8'h21);
    brd(5'd7); chk("R11 flag set", acc_rdata & 16'h00FF, 16'h0080);
    bwr(5'd7, 8'h7F);
    brd(5'd7); chk("R11 bit7 clear keeps", acc_rdata & 16'h00FF, 16'h0080);
    bwr(5'd7, 8'h80);
    brd(5'd7); chk("R11 bit7 set clears", acc_rdata & 16'h00FF, 16'h0000);

    // R10 wide write with page change in low byte
    access(1'b1, 1'b1, 5'd0, 16'h4B61);
    brd(5'd1); chk("R10 high byte new page", acc_rdata & 16'h00FF, 16'h004B);
    setpage(0);
    setpage(2);
    brd(5'd1); chk("R10 old page untouched", acc_rdata & 16'h00FF, {8'h00, m0[1]});

    // R10 wide reads and wrap
    setpage(0);
    bwr(5'd15, 8'h3D); bwr(5'd14, 8'h01);
    setpage(2);
    access(1'b0, 1'b1, 5'd14, 16'h0);
    chk("R10 wide read", acc_rdata, 16'h3D01);
    brd(5'd12);
    chk("R10 byte read keeps hi", acc_rdata, {8'h3D, m0[12]});
    access(1'b0, 1'b1, 5'd15, 16'h0);
    chk("R10 wide wrap", acc_rdata, 16'hA03D);

    // R5 discarded writes and stale reads
    bwr(5'd12, 8'h77);
    setpage(3);
    prev = acc_rdata;
    brd(5'd14); chk("R5 page3 stale", acc_rdata, prev);
    bwr(5'd14, 8'h99);
    setpage(2);
    brd(5'd14); chk("R5 page3 write dropped", acc_rdata & 16'h00FF, 16'h0001);
    brd(5'd12); chk("R5 page2 write dropped", acc_rdata & 16'h00FF, {8'h00, m0[12]});

    // R7 address truncation
    bwr(5'd0, 8'h22);
    bwr(5'd4, 8'hFF);
    bwr(5'd0, 8'h26);
    chk("R7 tx_addr mask", {1'b0, tx_req, tx_addr}, 16'h7F00);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule